// File: doc/BRIEF.md
# Exclusive Word Reservation Unit

This block carries out the paired exclusive-load and conditional-store operations of a processor pipeline. An exclusive load reads one aligned word from memory. It records that word address as the reservation, keeps the word it read, and returns the word for register write-back. It also clears the carry flag.

A later exclusive store succeeds only when two conditions hold: its aligned address equals the reservation, and the memory word still holds the value recorded at the load. In that case the new data replaces the memory word. Either way the reservation is dropped when the store finishes. The outcome is reported on the carry flag.

A small sequencer sequences the memory traffic. It issues a locked read, compares the word, and then issues a write only when the word is unchanged. While the sequencer runs, the unit shows busy and takes no new request. The word address used for every exclusive access has its two low bits forced to zero, so no alignment fault can arise.

Top module: `llsc_unit`

## Requirements
- R1: After reset the unit is idle (busy, done, mem_req, carry_we and wb_we all 0) and holds no reservation, so an exclusive store issued before any exclusive load fails with carry 1 and makes no memory access.
- R2: Every memory request uses the request address with bits [1:0] forced to 0.
- R3: An exclusive load reads the word and, on its done cycle, presents it on wb_data with wb_rd equal to the requested register; wb_we is 1 unless the register index is 0, in which case wb_we stays 0.
- R4: An exclusive load finishes with carry_we 1 and carry_val 0.
- R5: An exclusive store whose aligned address differs from the reservation fails with carry 1 and issues no memory request.
- R6: An exclusive store whose aligned address matches reads the word; if the word equals the recorded value, st_data is written there; otherwise memory is left unchanged.
- R7: A store's done cycle shows carry_we 1, with carry_val 0 on success and 1 on failure.
- R8: Every exclusive store, successful or not, drops the reservation, so a following store fails without a memory access until a new exclusive load.
- R9: busy is 1 from the cycle after a request is accepted until the done cycle, and requests that arrive while busy are ignored.
- R10: If an exclusive load and an exclusive store are requested in the same idle cycle, only the load is performed.
- R11: Success depends on the word value, not on whether it was written: a word changed and then restored to the recorded value still lets the store succeed.
- R12: A memory request keeps mem_req, mem_we and mem_addr unchanged until mem_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req | input | 1 | Exclusive-load request, sampled while idle |
| ld_addr | input | AW | Exclusive-load byte address |
| ld_rd | input | RW | Destination register index of the load |
| st_req | input | 1 | Exclusive-store request, sampled while idle |
| st_addr | input | AW | Exclusive-store byte address |
| st_data | input | DW | Data to store |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Holds memory for the atomic read–compare–write |
| mem_addr | output | AW | Word-aligned memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory accepts or answers the request |
| mem_rdata | input | DW | Memory read data, valid with mem_ack on a read |
| carry_we | output | 1 | Carry-flag update strobe |
| carry_val | output | 1 | New carry value |
| wb_we | output | 1 | Register write-back strobe |
| wb_rd | output | RW | Write-back register index |
| wb_data | output | DW | Write-back data |

## Verification
The embedded properties watch several rules on every clock cycle. They check that memory addresses stay word-aligned, that a pending request holds steady until it is acknowledged, and that writes target only the reserved word. They also check that a load never sets carry, that register 0 never receives a write, and that every store leaves the reservation invalid.

Some behaviours only the bench scenarios can show. These are the value-based success rule, including a word that is changed and then restored. They also cover the absence of memory traffic on an address mismatch or a spent reservation. The rest are: requests ignored while busy, load-over-store priority, and correct results under memory wait states.

// File: rtl/llsc_unit.sv
module llsc_unit #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_req,
  input  logic [AW-1:0] ld_addr,
  input  logic [RW-1:0] ld_rd,
  input  logic          st_req,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_lock,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          carry_we,
  output logic          carry_val,
  output logic          wb_we,
  output logic [RW-1:0] wb_rd,
  output logic [DW-1:0] wb_data
);

  localparam logic [AW-1:0] NO_RESV = '1;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_CMP, S_WRITE, S_DONE} state_t;

  state_t        state;
  logic          op_ld;
  logic          fail;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic [RW-1:0] op_rd;
  logic [DW-1:0] rd_val;
  logic [AW-1:0] res_addr;
  logic [DW-1:0] res_val;

  logic [AW-1:0] ld_al, st_al;
  assign ld_al = {ld_addr[AW-1:2], 2'b00};
  assign st_al = {st_addr[AW-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_ld    <= 1'b0;
      fail     <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
      op_rd    <= '0;
      rd_val   <= '0;
      res_addr <= NO_RESV;
      res_val  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ld_req) begin
            op_ld   <= 1'b1;
            op_addr <= ld_al;
            op_rd   <= ld_rd;
            fail    <= 1'b0;
            state   <= S_READ;
          end else if (st_req) begin
            op_ld   <= 1'b0;
            op_addr <= st_al;
            op_data <= st_data;
            op_rd   <= '0;
            fail    <= (st_al != res_addr);
            state   <= (st_al != res_addr) ? S_DONE : S_READ;
          end
        end
        S_READ: begin
          if (mem_ack) begin
            rd_val <= mem_rdata;
            state  <= op_ld ? S_DONE : S_CMP;
          end
        end
        S_CMP: begin
          if (rd_val == res_val) begin
            state <= S_WRITE;
          end else begin
            fail  <= 1'b1;
            state <= S_DONE;
          end
        end
        S_WRITE: begin
          if (mem_ack) state <= S_DONE;
        end
        S_DONE: begin
          if (op_ld) begin
            res_addr <= op_addr;
            res_val  <= rd_val;
          end else begin
            res_addr <= NO_RESV;
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign mem_req   = (state == S_READ) || (state == S_WRITE);
  assign mem_we    = (state == S_WRITE);
  assign mem_lock  = (state == S_READ) || (state == S_CMP) || (state == S_WRITE);
  assign mem_addr  = op_addr;
  assign mem_wdata = op_data;
  assign carry_we  = done;
  assign carry_val = done && !op_ld && fail;
  assign wb_we     = done && op_ld && (op_rd != '0);
  assign wb_rd     = op_rd;
  assign wb_data   = rd_val;

  p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_write_resv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == res_addr));

  p_load_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> (carry_we && !carry_val));

  p_no_r0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> (wb_rd != '0));

  p_resv_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wb_we && carry_we && !op_ld) |=> (res_addr == NO_RESV));

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ld_req || st_req));

endmodule

// File: tb/llsc_unit_tb.sv
`timescale 1ns/1ps
module llsc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_req = 1'b0, st_req = 1'b0;
  logic [31:0] ld_addr = '0, st_addr = '0, st_data = '0;
  logic [4:0]  ld_rd = '0;
  logic        busy, done, mem_req, mem_we, mem_lock, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        carry_we, carry_val, wb_we;
  logic [4:0]  wb_rd;
  logic [31:0] wb_data;

  always #2 clk = ~clk;

  llsc_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .ld_req(ld_req), .ld_addr(ld_addr), .ld_rd(ld_rd),
    .st_req(st_req), .st_addr(st_addr), .st_data(st_data),
    .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .carry_we(carry_we), .carry_val(carry_val),
    .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data)
  );

  logic [31:0] mem [16];
  int          stall = 0;
  int          wcnt = 0;
  assign mem_ack   = mem_req && (wcnt >= stall);
  assign mem_rdata = mem[mem_addr[5:2]];
  always @(posedge clk) begin
    if (mem_req && mem_ack && mem_we) mem[mem_addr[5:2]] <= mem_wdata;
    if (!mem_req || mem_ack) wcnt <= 0; else wcnt <= wcnt + 1;
  end

  logic acc_seen, wr_seen, misal;
  always @(negedge clk) begin
    if (mem_req) acc_seen = 1'b1;
    if (mem_req && mem_we) wr_seen = 1'b1;
    if (mem_req && mem_addr[1:0] != 2'b00) misal = 1'b1;
  end

  int total = 0, bad = 0;
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic        r_cwe, r_cv, r_wbwe, r_to;
  logic [31:0] r_wbd;
  logic [4:0]  r_rd;

  task automatic wait_done();
    r_to = 1'b1;
    for (int i = 0; i < 100; i++) begin
      if (done) begin
        r_to = 1'b0; r_cwe = carry_we; r_cv = carry_val;
        r_wbwe = wb_we; r_wbd = wb_data; r_rd = wb_rd;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic run_op(input bit is_ld, input logic [31:0] a, input logic [31:0] d, input logic [4:0] rd);
    acc_seen = 1'b0; wr_seen = 1'b0;
    if (is_ld) begin ld_req = 1'b1; ld_addr = a; ld_rd = rd; end
    else begin st_req = 1'b1; st_addr = a; st_data = d; end
    @(negedge clk);
    ld_req = 1'b0; st_req = 1'b0;
    wait_done();
  endtask

  typedef struct packed {
    logic        ld;
    logic [31:0] addr;
    logic [31:0] data;
    logic [4:0]  rd;
    logic        carry;
    logic        wbwe;
    logic [31:0] wbd;
    logic        acc;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 32'h0000_000B, 32'h0,         5'd3,  1'b0, 1'b1, 32'hA000_0002, 1'b1},
    '{1'b0, 32'h0000_0009, 32'h0000_1111, 5'd0,  1'b0, 1'b0, 32'h0,         1'b1},
    '{1'b0, 32'h0000_0008, 32'h0000_2222, 5'd0,  1'b1, 1'b0, 32'h0,         1'b0},
    '{1'b1, 32'h0000_0010, 32'h0,         5'd0,  1'b0, 1'b0, 32'h0,         1'b1},
    '{1'b0, 32'h0000_0014, 32'h0000_3333, 5'd0,  1'b1, 1'b0, 32'h0,         1'b0},
    '{1'b0, 32'h0000_0010, 32'h0000_3333, 5'd0,  1'b1, 1'b0, 32'h0,         1'b0},
    '{1'b1, 32'h0000_001E, 32'h0,         5'd31, 1'b0, 1'b1, 32'hA000_0007, 1'b1},
    '{1'b0, 32'h0000_001C, 32'h0000_4444, 5'd0,  1'b0, 1'b0, 32'h0,         1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 | i;
    misal = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req && !carry_we && !wb_we, "R1 reset outputs",
          {27'b0, busy, done, mem_req, carry_we, wb_we}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R5: no reservation after reset
    run_op(1'b0, 32'h0000_0000, 32'h5555, 5'd0);
    check(!r_to && r_cv && !acc_seen, "R1 store after reset fails",
          {30'b0, r_cv, acc_seen}, 32'h2);

    // R3 R4 R5 R6 R7 R8 table
    for (int k = 0; k < 8; k++) begin
      run_op(VEC[k].ld, VEC[k].addr, VEC[k].data, VEC[k].rd);
      check(!r_to && r_cwe && r_cv == VEC[k].carry, "R4/R7 carry", {31'b0, r_cv}, {31'b0, VEC[k].carry});
      check(r_wbwe == VEC[k].wbwe, "R3 wb_we", {31'b0, r_wbwe}, {31'b0, VEC[k].wbwe});
      if (VEC[k].wbwe) begin
        check(r_wbd == VEC[k].wbd, "R3 wb_data", r_wbd, VEC[k].wbd);
        check(r_rd == VEC[k].rd, "R3 wb_rd", {27'b0, r_rd}, {27'b0, VEC[k].rd});
      end
      check(acc_seen == VEC[k].acc, "R5/R8 memory access", {31'b0, acc_seen}, {31'b0, VEC[k].acc});
    end
    check(mem[2] == 32'h0000_1111, "R6 success writes", mem[2], 32'h0000_1111);
    check(mem[5] == 32'hA000_0005, "R5 mismatch leaves memory", mem[5], 32'hA000_0005);
    check(mem[7] == 32'h0000_4444, "R6 success writes word 7", mem[7], 32'h0000_4444);

    // R6 R11: value changed after load -> fail, memory untouched
    run_op(1'b1, 32'h0000_0014, 32'h0, 5'd2);
    @(negedge clk); mem[5] = 32'hDEAD_0005;
    run_op(1'b0, 32'h0000_0014, 32'h0000_6666, 5'd0);
    check(r_cv && acc_seen && !wr_seen, "R11 changed value fails", {30'b0, r_cv, wr_seen}, 32'h2);
    check(mem[5] == 32'hDEAD_0005, "R6 no write on mismatch", mem[5], 32'hDEAD_0005);
    run_op(1'b0, 32'h0000_0014, 32'h0000_6666, 5'd0);
    check(r_cv && !acc_seen, "R8 failed store drops reservation", {30'b0, r_cv, acc_seen}, 32'h2);

    // R11: changed then restored -> success
    run_op(1'b1, 32'h0000_0018, 32'h0, 5'd4);
    mem[6] = 32'h1234_5678;
    @(negedge clk);
    mem[6] = 32'hA000_0006;
    run_op(1'b0, 32'h0000_001B, 32'h0000_7777, 5'd0);
    check(!r_cv && wr_seen, "R11 restored value succeeds", {30'b0, r_cv, wr_seen}, 32'h1);
    check(mem[6] == 32'h0000_7777, "R11 restored write", mem[6], 32'h0000_7777);

    // R12: memory wait states
    stall = 3;
    run_op(1'b1, 32'h0000_0024, 32'h0, 5'd9);
    check(!r_to && r_wbwe && r_wbd == 32'hA000_0009, "R12 stalled load", r_wbd, 32'hA000_0009);
    run_op(1'b0, 32'h0000_0024, 32'h0000_8888, 5'd0);
    check(!r_to && !r_cv && mem[9] == 32'h0000_8888, "R12 stalled store", mem[9], 32'h0000_8888);
    stall = 0;

    // R9: busy and requests ignored while busy
    acc_seen = 1'b0;
    ld_req = 1'b1; ld_addr = 32'h0000_0028; ld_rd = 5'd1;
    @(negedge clk);
    ld_req = 1'b0;
    check(busy, "R9 busy after accept", {31'b0, busy}, 32'h1);
    st_req = 1'b1; st_addr = 32'h0000_0030; st_data = 32'h0000_9999;
    wait_done();
    st_req = 1'b0;
    check(!r_to && r_wbwe && r_wbd == 32'hA000_000A, "R9 load result", r_wbd, 32'hA000_000A);
    repeat (3) @(negedge clk);
    check(!busy, "R9 ignored request not queued", {31'b0, busy}, 32'h0);
    run_op(1'b0, 32'h0000_0028, 32'h0000_AAAA, 5'd0);
    check(!r_cv && mem[10] == 32'h0000_AAAA, "R9 reservation survived", mem[10], 32'h0000_AAAA);

    // R10: both at once -> load only
    acc_seen = 1'b0; wr_seen = 1'b0;
    ld_req = 1'b1; ld_addr = 32'h0000_002C; ld_rd = 5'd6;
    st_req = 1'b1; st_addr = 32'h0000_002C; st_data = 32'h0000_BBBB;
    @(negedge clk);
    ld_req = 1'b0; st_req = 1'b0;
    wait_done();
    check(r_wbwe && !r_cv && !wr_seen && r_wbd == 32'hA000_000B, "R10 load wins", r_wbd, 32'hA000_000B);

    check(!misal, "R2 aligned addresses", {31'b0, misal}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule